// File: doc/BRIEF.md
# ADC Conversion Status Register

This block is the read-only status register at the back end of a delta-sigma converter. It watches the strobes that start and finish conversions and calibrations and keeps an 8-bit status byte. The byte shows whether a result is waiting, whether the modulator is busy, and which rate code produced the held result or calibration. It also flags out-of-range results and a saturated gain calibration coefficient. Every raw conversion result is clipped to the signed output range before it is held.

The ready flag clears after a data read in one of two ways. A read that lands while a later conversion is running clears the flag on the next cycle. A read made while the modulator is idle is noted as pending, and the flag clears when the next conversion starts. If the result is never read, the flag stays set through the next start.

Top module: `adc_status_reg`

## Requirements
- R1: After reset, `status_byte`, `result` and `gain_coef` are all zero. Status byte encoding: bit 7 gain-coefficient saturation, bits 6:4 rate code, bit 3 high clip, bit 2 low clip, bit 1 busy, bit 0 ready.
- R2: A raw result above 0x7FFFFF (as a signed value) is held as 0x7FFFFF, and bit 3 is set on the cycle after `conv_done`.
- R3: A raw result below -0x800000 is held as 0x800000, and bit 2 is set on the cycle after `conv_done`.
- R4: A raw result inside the range, including exactly 0x7FFFFF and -0x800000, is held unchanged, and bits 3 and 2 are cleared.
- R5: Bit 1 is 1 from the cycle after `conv_start` or `cal_start` until the cycle after the matching `conv_done` or `cal_done`.
- R6: Bits 6:4 take the `rate_req` value captured at the last start, and only when that conversion or calibration finishes. While a new conversion is running, they keep the previous code.
- R7: Bit 0 is set on the cycle after `conv_done`.
- R8: A `data_rd` while a conversion is running clears bit 0 on the next cycle.
- R9: A `data_rd` while no conversion is running leaves bit 0 at 1 until the next `conv_start`, which clears it. With no read before `conv_start`, bit 0 stays 1.
- R10: When `conv_done` and `data_rd` occur in the same cycle, bit 0 stays 1, and that read does not clear the flag at the next start.
- R11: On `cal_done` with `cal_gain` high, a coefficient above 0xFFFFFF sets bit 7 and holds `gain_coef` at 0xFFFFFF. An in-range coefficient clears bit 7 and is held unchanged.
- R12: A `cal_done` with `cal_gain` low changes neither bit 7 nor `gain_coef`, and no calibration event changes bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| conv_start | input | 1 | Conversion start strobe |
| conv_done | input | 1 | Conversion finished strobe, raw result valid |
| cal_start | input | 1 | Calibration start strobe |
| cal_done | input | 1 | Calibration finished strobe |
| cal_gain | input | 1 | Qualifies `cal_done` as a system gain calibration |
| raw_result | input | 26 | Unclipped signed conversion result |
| rate_req | input | 3 | Rate code requested for the starting operation |
| coef_raw | input | 25 | Unsaturated gain coefficient (1 integer bit) |
| data_rd | input | 1 | Data register read completed |
| status_byte | output | 8 | Status byte |
| result | output | 24 | Clipped held result |
| gain_coef | output | 24 | Saturated gain coefficient |

## Verification
The bench builds the block with its default widths: a 24-bit result path fed by 26-bit raw values, and a 24-bit coefficient fed by a 25-bit unsaturated value. With these widths the exact range limits 0x7FFFFF and 0x800000 can be driven, along with values just past them in either direction and a coefficient one step above its ceiling. The stimulus covers both ready-clear paths, an unread result carried through a start, and a finish and read in the same cycle. It also covers calibrations that complete while an older result is still waiting.

// File: rtl/adc_stat_pkg.sv
package adc_stat_pkg;

   localparam int RATE_W = 3;

   typedef struct packed {
      logic              coef_sat;
      logic [RATE_W-1:0] rate;
      logic              clip_hi;
      logic              clip_lo;
      logic              busy;
      logic              ready;
   } stat_byte_t;

endpackage

// File: rtl/adc_range_clip.sv
module adc_range_clip #(
   parameter int IN_W  = 26,
   parameter int OUT_W = 24
) (
   input  logic signed [IN_W-1:0]  raw_in,
   output logic        [OUT_W-1:0] clipped,
   output logic                    over,
   output logic                    under
);

   localparam int EXT_W = IN_W - OUT_W + 1;

   generate
      if (IN_W == OUT_W) begin : g_pass
         assign clipped = raw_in;
         assign over    = 1'b0;
         assign under   = 1'b0;
      end else begin : g_clip
         localparam logic signed [IN_W-1:0] HI_LIM = {{EXT_W{1'b0}}, {(OUT_W-1){1'b1}}};
         localparam logic signed [IN_W-1:0] LO_LIM = {{EXT_W{1'b1}}, {(OUT_W-1){1'b0}}};

         logic signed [IN_W-1:0] sel;

         always_comb begin
            over  = raw_in > HI_LIM;
            under = raw_in < LO_LIM;
            if (over)       sel = HI_LIM;
            else if (under) sel = LO_LIM;
            else            sel = raw_in;
         end

         assign clipped = sel[OUT_W-1:0];
      end
   endgenerate

endmodule

// File: rtl/adc_coef_sat.sv
module adc_coef_sat #(
   parameter int IN_W  = 25,
   parameter int OUT_W = 24
) (
   input  logic [IN_W-1:0]  coef_in,
   output logic [OUT_W-1:0] coef_out,
   output logic             sat
);

   generate
      if (IN_W == OUT_W) begin : g_pass
         assign coef_out = coef_in;
         assign sat      = 1'b0;
      end else begin : g_sat
         assign sat      = |coef_in[IN_W-1:OUT_W];
         assign coef_out = sat ? {OUT_W{1'b1}} : coef_in[OUT_W-1:0];
      end
   endgenerate

endmodule

// File: rtl/adc_mod_activity.sv
module adc_mod_activity
   import adc_stat_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              conv_start,
   input  logic              conv_done,
   input  logic              cal_start,
   input  logic              cal_done,
   input  logic [RATE_W-1:0] rate_req,
   output logic              conv_busy,
   output logic              busy,
   output logic [RATE_W-1:0] held_rate
);

   logic              cal_busy;
   logic [RATE_W-1:0] run_rate;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         conv_busy <= 1'b0;
         cal_busy  <= 1'b0;
         run_rate  <= '0;
         held_rate <= '0;
      end else begin
         if (conv_done)       conv_busy <= 1'b0;
         else if (conv_start) conv_busy <= 1'b1;

         if (cal_done)        cal_busy <= 1'b0;
         else if (cal_start)  cal_busy <= 1'b1;

         if (conv_start || cal_start) run_rate <= rate_req;

         if (conv_done || cal_done)   held_rate <= run_rate;
      end
   end

   assign busy = conv_busy | cal_busy;

endmodule

// File: rtl/adc_ready_ctrl.sv
module adc_ready_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic conv_start,
   input  logic conv_done,
   input  logic conv_busy,
   input  logic data_rd,
   output logic ready
);

   logic rd_pending;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ready      <= 1'b0;
         rd_pending <= 1'b0;
      end else if (conv_done) begin
         ready      <= 1'b1;
         rd_pending <= 1'b0;
      end else if (conv_start) begin
         if (rd_pending || data_rd) ready <= 1'b0;
         rd_pending <= 1'b0;
      end else if (data_rd && ready) begin
         if (conv_busy) ready      <= 1'b0;
         else           rd_pending <= 1'b1;
      end
   end

endmodule

// File: rtl/adc_status_reg.sv
module adc_status_reg
   import adc_stat_pkg::*;
#(
   parameter int OUT_W  = 24,
   parameter int RAW_W  = 26,
   parameter int COEF_W = 24
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    conv_start,
   input  logic                    conv_done,
   input  logic                    cal_start,
   input  logic                    cal_done,
   input  logic                    cal_gain,
   input  logic signed [RAW_W-1:0] raw_result,
   input  logic [2:0]              rate_req,
   input  logic [COEF_W:0]         coef_raw,
   input  logic                    data_rd,
   output logic [7:0]              status_byte,
   output logic [OUT_W-1:0]        result,
   output logic [COEF_W-1:0]       gain_coef
);

   localparam int CIN_W = COEF_W + 1;

   generate
      if (RAW_W < OUT_W) begin : g_bad_raw
         $error("raw width must not be below output width");
      end
      if (OUT_W < 2) begin : g_bad_out
         $error("output width too small");
      end
      if (RATE_W != 3) begin : g_bad_rate
         $error("status byte needs a 3-bit rate field");
      end
   endgenerate

   logic [OUT_W-1:0]  clip_val;
   logic              clip_over, clip_under;
   logic [COEF_W-1:0] coef_val;
   logic              coef_over;
   logic              conv_busy, busy, ready;
   logic [RATE_W-1:0] held_rate;
   logic              hi_q, lo_q, sat_q;

   adc_range_clip #(.IN_W(RAW_W), .OUT_W(OUT_W)) u_clip (
      .raw_in  (raw_result),
      .clipped (clip_val),
      .over    (clip_over),
      .under   (clip_under)
   );

   adc_coef_sat #(.IN_W(CIN_W), .OUT_W(COEF_W)) u_sat (
      .coef_in  (coef_raw),
      .coef_out (coef_val),
      .sat      (coef_over)
   );

   adc_mod_activity u_act (
      .clk        (clk),
      .rst_n      (rst_n),
      .conv_start (conv_start),
      .conv_done  (conv_done),
      .cal_start  (cal_start),
      .cal_done   (cal_done),
      .rate_req   (rate_req),
      .conv_busy  (conv_busy),
      .busy       (busy),
      .held_rate  (held_rate)
   );

   adc_ready_ctrl u_rdy (
      .clk        (clk),
      .rst_n      (rst_n),
      .conv_start (conv_start),
      .conv_done  (conv_done),
      .conv_busy  (conv_busy),
      .data_rd    (data_rd),
      .ready      (ready)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         result    <= '0;
         hi_q      <= 1'b0;
         lo_q      <= 1'b0;
         sat_q     <= 1'b0;
         gain_coef <= '0;
      end else begin
         if (conv_done) begin
            result <= clip_val;
            hi_q   <= clip_over;
            lo_q   <= clip_under;
         end
         if (cal_done && cal_gain) begin
            gain_coef <= coef_val;
            sat_q     <= coef_over;
         end
      end
   end

   stat_byte_t sb;

   always_comb begin
      sb.coef_sat = sat_q;
      sb.rate     = held_rate;
      sb.clip_hi  = hi_q;
      sb.clip_lo  = lo_q;
      sb.busy     = busy;
      sb.ready    = ready;
   end

   assign status_byte = sb;

endmodule

// File: rtl/adc_status_chk.sv
module adc_status_chk #(
   parameter int OUT_W  = 24,
   parameter int RAW_W  = 26,
   parameter int COEF_W = 24
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    conv_start,
   input logic                    conv_done,
   input logic                    cal_done,
   input logic                    cal_gain,
   input logic signed [RAW_W-1:0] raw_result,
   input logic [COEF_W:0]         coef_raw,
   input logic [7:0]              status_byte,
   input logic [OUT_W-1:0]        result,
   input logic [COEF_W-1:0]       gain_coef
);

   localparam int EXT_W = RAW_W - OUT_W + 1;
   localparam logic signed [RAW_W-1:0] TOP_V = {{EXT_W{1'b0}}, {(OUT_W-1){1'b1}}};
   localparam logic signed [RAW_W-1:0] BOT_V = {{EXT_W{1'b1}}, {(OUT_W-1){1'b0}}};
   localparam logic [OUT_W-1:0] OUT_TOP = {1'b0, {(OUT_W-1){1'b1}}};
   localparam logic [OUT_W-1:0] OUT_BOT = {1'b1, {(OUT_W-1){1'b0}}};
   localparam logic [COEF_W:0]  COEF_TOP = {1'b0, {COEF_W{1'b1}}};

   // R7
   ready_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      conv_done |=> status_byte[0]);

   // R2
   clip_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_done && raw_result > TOP_V) |=> (status_byte[3] && result == OUT_TOP));

   // R3
   clip_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_done && raw_result < BOT_V) |=> (status_byte[2] && result == OUT_BOT));

   // R5
   busy_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_start && !conv_done && !cal_done) |=> status_byte[1]);

   // R6
   rate_moves_on_finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(status_byte[6:4]) |-> $past(conv_done || cal_done));

   // R11
   coef_saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cal_done && cal_gain && coef_raw > COEF_TOP) |=> (status_byte[7] && (&gain_coef)));

endmodule

bind adc_status_reg adc_status_chk #(
   .OUT_W  (OUT_W),
   .RAW_W  (RAW_W),
   .COEF_W (COEF_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .conv_start  (conv_start),
   .conv_done   (conv_done),
   .cal_done    (cal_done),
   .cal_gain    (cal_gain),
   .raw_result  (raw_result),
   .coef_raw    (coef_raw),
   .status_byte (status_byte),
   .result      (result),
   .gain_coef   (gain_coef)
);

// File: tb/tb_adc_status_reg.sv
`timescale 1ns/1ps
module tb_adc_status_reg;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               conv_start = 1'b0, conv_done = 1'b0;
   logic               cal_start = 1'b0, cal_done = 1'b0, cal_gain = 1'b0;
   logic signed [25:0] raw_result = '0;
   logic [2:0]         rate_req = '0;
   logic [24:0]        coef_raw = '0;
   logic               data_rd = 1'b0;
   logic [7:0]         status_byte;
   logic [23:0]        result;
   logic [23:0]        gain_coef;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   typedef struct {
      string       tag;
      logic [7:0]  st;
      logic [23:0] res;
      logic [23:0] coef;
   } exp_t;

   exp_t sb_q[$];

   always #10 clk = ~clk;

   adc_status_reg dut (
      .clk (clk), .rst_n (rst_n),
      .conv_start (conv_start), .conv_done (conv_done),
      .cal_start (cal_start), .cal_done (cal_done), .cal_gain (cal_gain),
      .raw_result (raw_result), .rate_req (rate_req), .coef_raw (coef_raw),
      .data_rd (data_rd),
      .status_byte (status_byte), .result (result), .gain_coef (gain_coef)
   );

   // status byte: [7] sat, [6:4] rate, [3] high, [2] low, [1] busy, [0] ready
   function automatic logic [7:0] sbyte(logic s, logic [2:0] r, logic h, logic l,
                                        logic b, logic y);
      return {s, r, h, l, b, y};
   endfunction

   task automatic tick(string tag, logic [7:0] st, logic [23:0] res, logic [23:0] cf);
      exp_t e;
      e.tag = tag; e.st = st; e.res = res; e.coef = cf;
      sb_q.push_back(e);
      @(posedge clk);
      #3;
      conv_start = 1'b0; conv_done = 1'b0; cal_start = 1'b0;
      cal_done = 1'b0; cal_gain = 1'b0; data_rd = 1'b0;
      @(negedge clk);
   endtask

   always begin
      @(posedge clk);
      #1;
      if (sb_q.size() > 0) begin
         exp_t e;
         e = sb_q.pop_front();
         checks++;
         if (status_byte !== e.st || result !== e.res || gain_coef !== e.coef) begin
            errors++;
            $display("FAIL %s: status=%h result=%h coef=%h expected status=%h result=%h coef=%h",
                     e.tag, status_byte, result, gain_coef, e.st, e.res, e.coef);
         end
      end
   end

   initial begin
      #2_000_000;
      if (!finished) begin
         errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      tick("R1 reset values", 8'h00, 24'h0, 24'h0);

      conv_start = 1; rate_req = 3;
      tick("R5 busy on start", sbyte(0,0,0,0,1,0), 24'h0, 24'h0);
      conv_done = 1; raw_result = 26'h0000123;
      tick("R7 ready on done, R4 R6", sbyte(0,3,0,0,0,1), 24'h000123, 24'h0);
      conv_start = 1; rate_req = 5;
      tick("R9 unread ready kept, R6 old rate", sbyte(0,3,0,0,1,1), 24'h000123, 24'h0);
      data_rd = 1;
      tick("R8 read during conversion", sbyte(0,3,0,0,1,0), 24'h000123, 24'h0);
      conv_done = 1; raw_result = 26'h0FFFFFF;
      tick("R2 high clip", sbyte(0,5,1,0,0,1), 24'h7FFFFF, 24'h0);
      data_rd = 1;
      tick("R9 idle read holds ready", sbyte(0,5,1,0,0,1), 24'h7FFFFF, 24'h0);
      conv_start = 1; rate_req = 1;
      tick("R9 start clears after idle read", sbyte(0,5,1,0,1,0), 24'h7FFFFF, 24'h0);
      conv_done = 1; raw_result = 26'h3000000;
      tick("R3 low clip", sbyte(0,1,0,1,0,1), 24'h800000, 24'h0);
      conv_start = 1; rate_req = 2;
      tick("R9 no read keeps ready", sbyte(0,1,0,1,1,1), 24'h800000, 24'h0);
      conv_done = 1; data_rd = 1; raw_result = 26'h3800000;
      tick("R10 done and read same cycle, R4 min", sbyte(0,2,0,0,0,1), 24'h800000, 24'h0);
      conv_start = 1; rate_req = 7;
      tick("R10 read not pending", sbyte(0,2,0,0,1,1), 24'h800000, 24'h0);
      conv_done = 1; raw_result = 26'h07FFFFF;
      tick("R4 max in range", sbyte(0,7,0,0,0,1), 24'h7FFFFF, 24'h0);
      cal_start = 1; rate_req = 6;
      tick("R5 busy on calibration", sbyte(0,7,0,0,1,1), 24'h7FFFFF, 24'h0);
      data_rd = 1;
      tick("R12 read during calibration", sbyte(0,7,0,0,1,1), 24'h7FFFFF, 24'h0);
      cal_done = 1; cal_gain = 1; coef_raw = 25'h1000000;
      tick("R11 coefficient saturates", sbyte(1,6,0,0,0,1), 24'h7FFFFF, 24'hFFFFFF);
      conv_start = 1; rate_req = 4;
      tick("R9 pending read from calibration time", sbyte(1,6,0,0,1,0), 24'h7FFFFF, 24'hFFFFFF);
      conv_done = 1; raw_result = 26'h3FFFFFF;
      tick("R4 minus one", sbyte(1,4,0,0,0,1), 24'hFFFFFF, 24'hFFFFFF);
      cal_start = 1; rate_req = 0;
      tick("R12 calibration keeps ready", sbyte(1,4,0,0,1,1), 24'hFFFFFF, 24'hFFFFFF);
      cal_done = 1; cal_gain = 1; coef_raw = 25'h0800000;
      tick("R11 coefficient in range", sbyte(0,0,0,0,0,1), 24'hFFFFFF, 24'h800000);
      cal_start = 1; rate_req = 3;
      tick("R5 second calibration", sbyte(0,0,0,0,1,1), 24'hFFFFFF, 24'h800000);
      cal_done = 1; coef_raw = 25'h1FFFFFF;
      tick("R12 non-gain calibration", sbyte(0,3,0,0,0,1), 24'hFFFFFF, 24'h800000);

      repeat (2) @(negedge clk);
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule